// File: doc/BRIEF.md
# Linked-Descriptor Memory Copy Engine

This block is a single-channel copy engine that works through a chain of descriptors kept in memory. Software writes descriptors into memory, then pulses a start input with the address of the first one. The engine reads the six words of that descriptor over a word-wide memory master port, moves 32-bit words from a source region to a destination region, flags completion, and moves on to the descriptor named in the link word. A link of zero ends the chain.

Each descriptor selects linear mode, where the length word is one byte count, or two-dimensional mode, where the length word holds a row count and a per-row byte count and a stride word holds signed per-row address adjustments. Either address may stay fixed or step by 4 per beat. The read may be skipped so that zero is written, and the write may be suppressed so that only reads happen. The memory port carries one request at a time and holds it until the memory answers with ready.

Top module: `chain_dma_engine`

## Requirements
- R1: After a start, the engine issues six reads at descriptor address +0, +4, +8, +12, +16, +20 in that order, one request at a time, and holds request, address and write enable unchanged until ready is seen with the request.
- R2: In linear mode (control word bit 1 clear) the whole length word is the byte count; each beat moves one word and takes 4 off the count, and a remainder below 4 still costs one beat and brings the count to zero.
- R3: The source address steps by 4 after each beat only when control bit 8 is set, and the destination address steps by 4 only when control bit 4 is set; otherwise each stays fixed.
- R4: With control bit 11 set no source read is issued and every destination write carries zero.
- R5: With control bit 7 set no destination write is issued, while the source reads still take place.
- R6: In two-dimensional mode (control bit 1 set) the row count is length bits [29:16] and the per-row byte count is bits [15:0]; between rows, but not after the last, the source address is adjusted by the signed stride bits [15:0] and the destination by the signed stride bits [31:16].
- R7: A row whose byte count is zero, or a two-dimensional descriptor with zero rows, completes with no data beats.
- R8: The live length output shows the remaining bytes in linear mode and, in two-dimensional mode, remaining rows in [29:16] with remaining bytes of the current row in [15:0]; it reads zero once a descriptor finishes.
- R9: At the end of every descriptor the end flag is set; if control bit 0 is set the interrupt output is also set. The end clear and interrupt clear inputs each drop only their own flag.
- R10: After a descriptor the current-descriptor output takes the link word; a nonzero link starts a new fetch there, a zero link ends the chain with busy low and paused high. A start with address zero sets paused without any request.
- R11: The enable input is sampled at start and at each descriptor boundary only: with it low a start issues no request, and dropping it during a descriptor lets that descriptor finish and then stops with the link address held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Channel enable, checked at start and between descriptors |
| start | input | 1 | One-cycle pulse that begins a chain when idle |
| start_desc | input | AW | Byte address of the first descriptor |
| end_clr | input | 1 | Clears the end flag |
| int_clr | input | 1 | Clears the interrupt output |
| mem_req | output | 1 | Memory request |
| mem_addr | output | AW | Memory byte address |
| mem_we | output | 1 | Write enable of the request |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with ready |
| mem_ready | input | 1 | Memory completes the current request |
| busy | output | 1 | Chain in progress |
| paused | output | 1 | Chain has stopped |
| end_flag | output | 1 | A descriptor has completed |
| irq | output | 1 | Interrupt flag |
| cur_desc | output | AW | Address of the current descriptor |
| live_len | output | 32 | Remaining transfer length |

## Verification
The bench aims at the step between rows with a negative destination stride, where a design that applied the stride after the last row or treated it as unsigned would scatter words to the wrong addresses, and at zero-byte rows and zero-row descriptors, where a design that always ran one beat would write a stray word. It skips reads and writes separately and counts the memory accesses, so an engine that still issued the skipped access or wrote stale data instead of zero is caught. It also drops the enable mid-descriptor and starts with a zero address, which expose an engine that checks the enable per beat or fetches from address zero, and it compares live length after the first beat to catch a wrong field packing.

// File: rtl/dma_chain_pkg.sv
`timescale 1ns/1ps
package dma_chain_pkg;
   typedef enum logic [3:0] {
      ST_IDLE, ST_FETCH0, ST_FETCH1, ST_FETCH2, ST_FETCH3, ST_FETCH4, ST_FETCH5,
      ST_ROW_START, ST_READ, ST_WRITE, ST_ROW_END, ST_DESC_END
   } dma_state_e;

   // control word bit positions, decoded from descriptors written by software
   localparam int CTL_INT_EN   = 0;
   localparam int CTL_TWO_D    = 1;
   localparam int CTL_DST_INC  = 4;
   localparam int CTL_DST_SKIP = 7;
   localparam int CTL_SRC_INC  = 8;
   localparam int CTL_SRC_SKIP = 11;

   typedef struct packed {
      logic src_skip;
      logic src_inc;
      logic dst_skip;
      logic dst_inc;
      logic two_d;
      logic int_en;
   } dma_ctl_t;
endpackage

// File: rtl/dma_len_ctrl.sv
`timescale 1ns/1ps
module dma_len_ctrl #(
   parameter int ROW_W     = 14,
   parameter bit ENABLE_2D = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        load,
   input  logic [31:0] len_word,
   input  logic        two_d_req,
   input  logic        beat_done,
   input  logic        row_done,
   output logic        rows_zero,
   output logic        bytes_zero,
   output logic        last_row,
   output logic        last_beat,
   output logic [31:0] live_len
);
   localparam int ROW_LSB = 16;

   logic             mode_in, mode_q;
   logic [ROW_W-1:0] rows_q;
   logic [31:0]      bytes_q;
   logic [15:0]      reload_q;

   generate
      if (ENABLE_2D) begin : g_two_d
         assign mode_in = two_d_req;
      end else begin : g_linear_only
         assign mode_in = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= 1'b0;
         rows_q   <= '0;
         bytes_q  <= '0;
         reload_q <= '0;
      end else if (load) begin
         mode_q   <= mode_in;
         reload_q <= len_word[15:0];
         if (mode_in) begin
            rows_q  <= len_word[ROW_LSB +: ROW_W];
            bytes_q <= 32'(len_word[15:0]);
         end else begin
            rows_q  <= ROW_W'(1);
            bytes_q <= len_word;
         end
      end else if (beat_done) begin
         bytes_q <= last_beat ? '0 : bytes_q - 32'd4;
      end else if (row_done) begin
         rows_q <= rows_q - ROW_W'(1);
         if (!last_row) bytes_q <= 32'(reload_q);
      end
   end

   assign rows_zero  = (rows_q == '0);
   assign bytes_zero = (bytes_q == '0);
   assign last_row   = (rows_q == ROW_W'(1));
   assign last_beat  = (bytes_q <= 32'd4);
   assign live_len   = mode_q ? ((32'(rows_q) << ROW_LSB) | 32'(bytes_q[15:0])) : bytes_q;

   // R2: a beat never makes the count grow
   p_count_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
      beat_done && !load |=> bytes_q < $past(bytes_q) || bytes_q == '0);
endmodule

// File: rtl/dma_addr_gen.sv
`timescale 1ns/1ps
module dma_addr_gen #(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] src_init,
   input  logic [AW-1:0] dst_init,
   input  logic [31:0]   stride_word,
   input  logic          src_step,
   input  logic          dst_step,
   input  logic          row_adv,
   output logic [AW-1:0] src_addr,
   output logic [AW-1:0] dst_addr
);
   logic [AW-1:0] src_stride, dst_stride;

   assign src_stride = AW'(signed'(stride_word[15:0]));
   assign dst_stride = AW'(signed'(stride_word[31:16]));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_addr <= '0;
         dst_addr <= '0;
      end else if (load) begin
         src_addr <= src_init;
         dst_addr <= dst_init;
      end else begin
         if (src_step) src_addr <= src_addr + AW'(4);
         if (dst_step) dst_addr <= dst_addr + AW'(4);
         if (row_adv) begin
            src_addr <= src_addr + src_stride;
            dst_addr <= dst_addr + dst_stride;
         end
      end
   end

   // R3: the source pointer moves only on a step, a row advance or a load
   p_src_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(load || src_step || row_adv) |=> $stable(src_addr));
   p_dst_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(load || dst_step || row_adv) |=> $stable(dst_addr));
endmodule

// File: rtl/chain_dma_engine.sv
`timescale 1ns/1ps
module chain_dma_engine
   import dma_chain_pkg::*;
#(
   parameter int AW        = 32,
   parameter int ROW_W     = 14,
   parameter bit ENABLE_2D = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          chan_en,
   input  logic          start,
   input  logic [AW-1:0] start_desc,
   input  logic          end_clr,
   input  logic          int_clr,
   output logic          mem_req,
   output logic [AW-1:0] mem_addr,
   output logic          mem_we,
   output logic [31:0]   mem_wdata,
   input  logic [31:0]   mem_rdata,
   input  logic          mem_ready,
   output logic          busy,
   output logic          paused,
   output logic          end_flag,
   output logic          irq,
   output logic [AW-1:0] cur_desc,
   output logic [31:0]   live_len
);
   generate
      if (AW < 12 || AW > 32) begin : g_bad_aw
         $error("AW must lie in 12..32");
      end
      if (ROW_W < 1 || ROW_W > 16) begin : g_bad_row_w
         $error("ROW_W must lie in 1..16");
      end
   endgenerate

   dma_state_e    state;
   dma_ctl_t      ctl_q;
   logic [AW-1:0] desc_q, src_w, dst_w, next_w;
   logic [31:0]   len_w, stride_w, data_q;
   logic          end_q, irq_q, paused_q;
   logic [AW-1:0] src_addr, dst_addr;
   logic [2:0]    fidx;
   logic          is_fetch, rd_fin, wr_fin, load;
   logic          rows_zero, bytes_zero, last_row, last_beat;

   assign is_fetch = (state >= ST_FETCH0) && (state <= ST_FETCH5);
   assign fidx     = 3'(4'(state) - 4'(ST_FETCH0));
   assign rd_fin   = (state == ST_READ)  && (ctl_q.src_skip || mem_ready);
   assign wr_fin   = (state == ST_WRITE) && (ctl_q.dst_skip || mem_ready);
   assign load     = (state == ST_FETCH5) && mem_ready;

   always_comb begin
      mem_req   = 1'b0;
      mem_addr  = '0;
      mem_we    = 1'b0;
      mem_wdata = data_q;
      if (is_fetch) begin
         mem_req  = 1'b1;
         mem_addr = desc_q + AW'({fidx, 2'b00});
      end else if (state == ST_READ) begin
         mem_req  = !ctl_q.src_skip;
         mem_addr = src_addr;
      end else if (state == ST_WRITE) begin
         mem_req  = !ctl_q.dst_skip;
         mem_addr = dst_addr;
         mem_we   = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         ctl_q    <= '0;
         desc_q   <= '0;
         src_w    <= '0;
         dst_w    <= '0;
         next_w   <= '0;
         len_w    <= '0;
         stride_w <= '0;
         data_q   <= '0;
         end_q    <= 1'b0;
         irq_q    <= 1'b0;
         paused_q <= 1'b0;
      end else begin
         if (end_clr) end_q <= 1'b0;
         if (int_clr) irq_q <= 1'b0;
         if (rd_fin) data_q <= ctl_q.src_skip ? '0 : mem_rdata;
         case (state)
            ST_IDLE: if (start) begin
               desc_q <= start_desc;
               if (chan_en && start_desc != '0) begin
                  paused_q <= 1'b0;
                  state    <= ST_FETCH0;
               end else begin
                  paused_q <= 1'b1;
               end
            end
            ST_FETCH0: if (mem_ready) begin
               ctl_q <= '{src_skip: mem_rdata[CTL_SRC_SKIP], src_inc: mem_rdata[CTL_SRC_INC],
                          dst_skip: mem_rdata[CTL_DST_SKIP], dst_inc: mem_rdata[CTL_DST_INC],
                          two_d: mem_rdata[CTL_TWO_D], int_en: mem_rdata[CTL_INT_EN]};
               state <= ST_FETCH1;
            end
            ST_FETCH1: if (mem_ready) begin src_w    <= mem_rdata[AW-1:0]; state <= ST_FETCH2; end
            ST_FETCH2: if (mem_ready) begin dst_w    <= mem_rdata[AW-1:0]; state <= ST_FETCH3; end
            ST_FETCH3: if (mem_ready) begin len_w    <= mem_rdata;         state <= ST_FETCH4; end
            ST_FETCH4: if (mem_ready) begin stride_w <= mem_rdata;         state <= ST_FETCH5; end
            ST_FETCH5: if (mem_ready) begin next_w   <= mem_rdata[AW-1:0]; state <= ST_ROW_START; end
            ST_ROW_START: begin
               if (rows_zero)       state <= ST_DESC_END;
               else if (bytes_zero) state <= ST_ROW_END;
               else                 state <= ST_READ;
            end
            ST_READ:    if (rd_fin) state <= ST_WRITE;
            ST_WRITE:   if (wr_fin) state <= last_beat ? ST_ROW_END : ST_READ;
            ST_ROW_END: state <= last_row ? ST_DESC_END : ST_ROW_START;
            ST_DESC_END: begin
               end_q  <= 1'b1;
               if (ctl_q.int_en) irq_q <= 1'b1;
               desc_q <= next_w;
               if (chan_en && next_w != '0) begin
                  state <= ST_FETCH0;
               end else begin
                  state    <= ST_IDLE;
                  paused_q <= 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   dma_len_ctrl #(.ROW_W(ROW_W), .ENABLE_2D(ENABLE_2D)) u_len (
      .clk(clk), .rst_n(rst_n), .load(load), .len_word(len_w), .two_d_req(ctl_q.two_d),
      .beat_done(wr_fin), .row_done(state == ST_ROW_END),
      .rows_zero(rows_zero), .bytes_zero(bytes_zero), .last_row(last_row),
      .last_beat(last_beat), .live_len(live_len)
   );

   dma_addr_gen #(.AW(AW)) u_addr (
      .clk(clk), .rst_n(rst_n), .load(load), .src_init(src_w), .dst_init(dst_w),
      .stride_word(stride_w), .src_step(rd_fin && ctl_q.src_inc),
      .dst_step(wr_fin && ctl_q.dst_inc), .row_adv((state == ST_ROW_END) && !last_row),
      .src_addr(src_addr), .dst_addr(dst_addr)
   );

   assign busy     = (state != ST_IDLE);
   assign paused   = paused_q;
   assign end_flag = end_q;
   assign irq      = irq_q;
   assign cur_desc = desc_q;

   // R1: a pending request is held steady until the memory answers
   p_req_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we));
   // R10: no memory traffic while idle, and paused only when idle
   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req);
   p_pause_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      paused |-> !busy);
   // R9: the interrupt only rises together with descriptor completion
   p_int_with_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> end_flag);
endmodule

// File: tb/chain_dma_engine_bench.sv
`timescale 1ns/1ps
module chain_dma_engine_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        chan_en = 1'b1, start = 1'b0, end_clr = 1'b0, int_clr = 1'b0;
   logic [31:0] start_desc = '0;
   logic        mem_req, mem_we, mem_ready = 1'b0;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic        busy, paused, end_flag, irq;
   logic [31:0] cur_desc, live_len;

   logic [31:0] mem [0:1023];
   logic [31:0] exp_mem [0:1023];
   int checks = 0, errors = 0;
   int rd_cnt = 0, wr_cnt = 0, log_n = 0, wait_cnt = 0, lat = 0;
   logic [31:0] acc_log [0:15];
   logic        first_wr = 1'b0, grab = 1'b0;
   logic [31:0] len_mid = '0;
   bit          exp_irq;

   always #4 clk = ~clk;

   chain_dma_engine u_chain_dma_engine (
      .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .start(start), .start_desc(start_desc),
      .end_clr(end_clr), .int_clr(int_clr), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
      .busy(busy), .paused(paused), .end_flag(end_flag), .irq(irq),
      .cur_desc(cur_desc), .live_len(live_len)
   );

   assign mem_rdata = mem[mem_addr[11:2]];

   always @(posedge clk) begin
      if (mem_req && mem_ready) begin
         wait_cnt = 0;
         if (log_n < 16) begin acc_log[log_n] = mem_addr; log_n++; end
         if (mem_we) begin
            mem[mem_addr[11:2]] = mem_wdata;
            wr_cnt++;
            if (!first_wr) begin first_wr = 1'b1; grab = 1'b1; end
         end else rd_cnt++;
      end
   end

   always @(negedge clk) begin
      if (grab) begin len_mid = live_len; grab = 1'b0; end
      if (mem_req && wait_cnt >= lat) mem_ready = 1'b1;
      else begin
         mem_ready = 1'b0;
         if (mem_req) wait_cnt++;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; chan_en = 1'b1;
      repeat (2) @(negedge clk);
      rd_cnt = 0; wr_cnt = 0; log_n = 0; first_wr = 1'b0; len_mid = '0;
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic put_desc(input logic [31:0] a, input logic [31:0] ctl, input logic [31:0] s,
                           input logic [31:0] d, input logic [31:0] len,
                           input logic [31:0] stride, input logic [31:0] nxt);
      mem[a[11:2]] = ctl;     mem[a[11:2]+1] = s;      mem[a[11:2]+2] = d;
      mem[a[11:2]+3] = len;   mem[a[11:2]+4] = stride; mem[a[11:2]+5] = nxt;
   endtask

   // expected outcome computed from the requirements, one beat at a time
   task automatic model_chain(input logic [31:0] dsc, input bit en);
      exp_irq = 1'b0;
      for (int i = 0; i < 1024; i++) exp_mem[i] = mem[i];
      if (!en) return;
      while (dsc != 0) begin
         logic [31:0] ctl, s, d, len, strd, nxt, b, data;
         int rows;
         ctl = exp_mem[dsc[11:2]];   s = exp_mem[dsc[11:2]+1]; d = exp_mem[dsc[11:2]+2];
         len = exp_mem[dsc[11:2]+3]; strd = exp_mem[dsc[11:2]+4]; nxt = exp_mem[dsc[11:2]+5];
         rows = ctl[1] ? int'(len[29:16]) : 1;
         for (int r = 0; r < rows; r++) begin
            b = ctl[1] ? {16'h0, len[15:0]} : len;
            while (b != 0) begin
               data = ctl[11] ? 32'h0 : exp_mem[s[11:2]];
               if (ctl[8]) s += 4;
               if (!ctl[7]) exp_mem[d[11:2]] = data;
               if (ctl[4]) d += 4;
               b = (b <= 4) ? 32'h0 : b - 4;
            end
            if (r < rows - 1) begin
               s += {{16{strd[15]}}, strd[15:0]};
               d += {{16{strd[31]}}, strd[31:16]};
            end
         end
         if (ctl[0]) exp_irq = 1'b1;
         dsc = nxt;
      end
   endtask

   task automatic run_chain(input logic [31:0] dsc);
      model_chain(dsc, chan_en);
      rd_cnt = 0; wr_cnt = 0; log_n = 0; first_wr = 1'b0;
      start_desc = dsc; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 20000 && busy; k++) @(negedge clk);
   endtask

   task automatic cmp_mem(input string req);
      int bad = 0, first = -1;
      for (int i = 0; i < 1024; i++)
         if (mem[i] !== exp_mem[i]) begin bad++; if (first < 0) first = i; end
      if (first < 0) first = 0;
      chk(bad == 0, req, $sformatf("memory word %0d", first), mem[first], exp_mem[first]);
   endtask

   task automatic fill(input int base, input int n, input logic [31:0] seed);
      for (int i = 0; i < n; i++) mem[base/4 + i] = seed + 32'h0101_0101 * i;
   endtask

   task automatic t_reset();
      do_reset();
      chk(!busy && !mem_req, "R10", "busy/req after reset", {busy, mem_req}, 0);
      chk(!paused, "R10", "paused after reset", paused, 0);
      chk(!end_flag && !irq, "R9", "flags after reset", {end_flag, irq}, 0);
      chk(live_len == 0, "R8", "live length after reset", live_len, 0);
   endtask

   task automatic t_linear();
      bit ok = 1'b1;
      do_reset(); lat = 1;
      fill(32'h400, 4, 32'hA0B0_C0D0);
      put_desc(32'h100, 32'h111, 32'h400, 32'h800, 16, 0, 0);
      run_chain(32'h100);
      for (int i = 0; i < 6; i++) if (acc_log[i] != 32'h100 + 4*i) ok = 1'b0;
      chk(ok, "R1", "descriptor fetch order", acc_log[5], 32'h114);
      cmp_mem("R2 R3");
      chk(rd_cnt == 10 && wr_cnt == 4, "R2", "beats for 16 bytes", rd_cnt*256+wr_cnt, 10*256+4);
      chk(len_mid == 12, "R8", "live length after first beat", len_mid, 12);
      chk(live_len == 0, "R8", "live length at end", live_len, 0);
      chk(end_flag && irq, "R9", "end and interrupt", {end_flag, irq}, 2'b11);
      chk(paused && !busy && cur_desc == 0, "R10", "chain stop", {paused, busy, cur_desc}, {2'b10, 32'h0});
   endtask

   task automatic t_fixed_addr();
      do_reset(); lat = 0;
      fill(32'h400, 4, 32'h1234_0000);
      put_desc(32'h100, 32'h100, 32'h400, 32'hA00, 12, 0, 0);
      run_chain(32'h100);
      cmp_mem("R3");
      chk(wr_cnt == 3 && irq == 0, "R9", "no interrupt without enable bit", {wr_cnt[7:0], irq}, {8'd3, 1'b0});
      chk(end_flag, "R9", "end flag without interrupt enable", end_flag, 1);
      put_desc(32'h100, 32'h010, 32'h40C, 32'hA10, 10, 0, 0);
      run_chain(32'h100);
      cmp_mem("R3");
      chk(wr_cnt == 3, "R2", "length 10 takes three beats", wr_cnt, 3);
   endtask

   task automatic t_skip();
      do_reset(); lat = 1;
      fill(32'hB00, 2, 32'h5555_AAAA);
      put_desc(32'h100, 32'h810, 32'h400, 32'hB00, 8, 0, 0);
      run_chain(32'h100);
      cmp_mem("R4");
      chk(rd_cnt == 6 && mem[32'hB00/4] == 0, "R4", "no source reads, zero data", rd_cnt, 6);
      put_desc(32'h100, 32'h180, 32'h400, 32'hB00, 8, 0, 0);
      run_chain(32'h100);
      chk(wr_cnt == 0 && rd_cnt == 8, "R5", "reads without writes", rd_cnt*256+wr_cnt, 8*256);
      cmp_mem("R5");
   endtask

   task automatic t_two_d();
      do_reset(); lat = 2;
      fill(32'h600, 12, 32'h7700_0001);
      put_desc(32'h140, 32'h113, 32'h600, 32'h900, (3 << 16) | 8, {16'hFFE8, 16'h0008}, 0);
      run_chain(32'h140);
      cmp_mem("R6");
      chk(wr_cnt == 6 && rd_cnt == 12, "R6", "beats over three rows", rd_cnt*256+wr_cnt, 12*256+6);
      chk(mem[32'h8E4/4] == mem[32'h624/4], "R6", "last row placed by negative stride",
          mem[32'h8E4/4], mem[32'h624/4]);
      chk(len_mid == 32'h0003_0004, "R8", "2D live length after first beat", len_mid, 32'h0003_0004);
      chk(live_len == 0, "R8", "2D live length at end", live_len, 0);
   endtask

   task automatic t_zero_chain();
      do_reset(); lat = 0;
      fill(32'h400, 1, 32'hCAFE_0001);
      put_desc(32'h180, 32'h002, 32'h400, 32'hC00, (2 << 16), 0, 32'h1C0);
      put_desc(32'h1C0, 32'h111, 32'h400, 32'hC40, 4, 0, 0);
      run_chain(32'h180);
      chk(acc_log[6] == 32'h1C0, "R10", "second descriptor fetched at link", acc_log[6], 32'h1C0);
      chk(wr_cnt == 1 && rd_cnt == 13, "R7", "zero-byte rows move nothing", rd_cnt*256+wr_cnt, 13*256+1);
      cmp_mem("R7");
      chk(irq == exp_irq && end_flag, "R9", "interrupt from second descriptor", irq, exp_irq);
      end_clr = 1'b1; @(negedge clk); end_clr = 1'b0;
      chk(!end_flag && irq, "R9", "end clear leaves interrupt", {end_flag, irq}, 2'b01);
      int_clr = 1'b1; @(negedge clk); int_clr = 1'b0;
      chk(!irq, "R9", "interrupt clear", irq, 0);
      put_desc(32'h180, 32'h003, 32'h400, 32'hC00, 8, 0, 0);
      run_chain(32'h180);
      chk(wr_cnt == 0 && end_flag && irq, "R7", "zero rows complete at once", wr_cnt, 0);
   endtask

   task automatic t_enable();
      do_reset(); lat = 0;
      put_desc(32'h100, 32'h111, 32'h400, 32'hD00, 8, 0, 0);
      chan_en = 1'b0;
      run_chain(32'h100);
      chk(rd_cnt == 0 && paused && !end_flag, "R11", "start while disabled", rd_cnt, 0);
      chan_en = 1'b1;
      run_chain(32'h0);
      chk(rd_cnt == 0 && paused, "R10", "start at address zero", rd_cnt, 0);
      do_reset(); lat = 2;
      put_desc(32'h100, 32'h111, 32'h400, 32'hD00, 8, 0, 32'h1C0);
      put_desc(32'h1C0, 32'h111, 32'h400, 32'hD40, 8, 0, 0);
      start_desc = 32'h100; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (2) @(negedge clk);
      chan_en = 1'b0;
      for (int k = 0; k < 20000 && busy; k++) @(negedge clk);
      chk(rd_cnt == 8 && wr_cnt == 2, "R11", "descriptor finishes after disable", rd_cnt*256+wr_cnt, 8*256+2);
      chk(cur_desc == 32'h1C0 && paused, "R11", "stop with link held", cur_desc, 32'h1C0);
      chan_en = 1'b1;
   endtask

   initial begin
      for (int i = 0; i < 1024; i++) mem[i] = '0;
      t_reset();
      t_linear();
      t_fixed_addr();
      t_skip();
      t_two_d();
      t_zero_chain();
      t_enable();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: run did not end, actual %0d expected %0d", 200000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule